// File: doc/BRIEF.md
# Serial Flash Erase Command Decoder

This block is the device-side command logic of a serial flash part. It takes SPI mode 0 frames and serves two erase commands: erasing one page, and erasing an aligned group of eight pages. A frame is one opcode byte followed by a 24-bit address field. The page number is taken from that field at a position set by a page-size mode input, which selects either 264-byte or 256-byte pages. The bits around the page number are ignored.

An erase is armed only when chip select is released after a full frame. It then runs from the system clock with no further host activity. A self-timed sequencer pulses a start strobe toward the memory array and gives the first page and the page count. It holds a busy flag for a parameter-set number of cycles, and the block erase runs longer than the page erase. A status read opcode returns the busy flag over MISO at any time. A behavioural array stand-in records erased pages in a small tracked window, and a probe port reads them back.

Top module: `sflash_erase_ctl`

## Requirements
- R1: A frame with opcode 0x81 produces one single-cycle `arr_erase_start` pulse with `arr_page_count` = 1 and `arr_first_page` = the decoded page number.
- R2: A frame with opcode 0x50 produces one start pulse with `arr_page_count` = 8 and `arr_first_page` = block number × 8. The block number is the upper 9 bits of the 12-bit page field, and the lower 3 page bits are ignored.
- R3: With `page256_mode` = 0, the address field is numbered 23 (first bit sent) down to 0. The page number is bits 20..9, and the block number is bits 20..12. All other address bits are ignored.
- R4: With `page256_mode` = 1, the page number is address bits 19..8, and the block number is bits 19..11. All other address bits are ignored.
- R5: MOSI is sampled on rising SCK edges, most significant bit first. An erase starts only on the rising edge of `spi_cs_n` after at least 32 bits have been received in the frame. The start pulse comes 4 system clocks after the chip-select rise enters the block. A shorter frame starts nothing.
- R6: A complete frame whose opcode is neither 0x81 nor 0x50 starts nothing.
- R7: `erase_busy` rises in the same cycle as the start pulse. It stays high for exactly PAGE_CYC cycles after a page erase, or BLOCK_CYC cycles after a block erase (BLOCK_CYC > PAGE_CYC).
- R8: An erase frame whose chip-select release is decoded while `erase_busy` is high is ignored and leaves the array unchanged.
- R9: After opcode 0x05, MISO shifts out a status byte MSB first, changing after each falling SCK edge. Bit 7 is the busy flag, bit 0 is `page256_mode`, and the other bits are 0. This works during an erase too.
- R10: In the array stand-in, pages below TRACK_PAGES read 0x00 on `probe_data` after reset and 0xFF (all ones) once an erase has covered them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host (status byte) |
| page256_mode | input | 1 | 1 = 256-byte page layout, 0 = 264-byte layout |
| erase_busy | output | 1 | Erase in progress |
| arr_erase_start | output | 1 | One-cycle erase strobe to the array |
| arr_first_page | output | PAGE_W | First page to erase |
| arr_page_count | output | BLK_SHIFT+1 | Number of pages to erase (1 or 8) |
| probe_page | input | PAGE_W | Page to inspect in the array stand-in |
| probe_data | output | 8 | Byte value of the probed page |

## Verification
Two things can happen in the same cycle: the front end decodes a chip-select release for a new command while the erase timer is still counting. This shows up in two ways. A status read is issued right after a block erase starts, and it must return bit 7 set while the timer runs. A second page erase is sent right behind a first one, so that its release is decoded while busy is high. A reference model in the bench predicts the busy and start outputs cycle by cycle from the chip-select release times. The second erase must give no start pulse, and its page must still read 0x00 afterwards.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam logic [7:0] OPC_ERASE_PAGE  = 8'h81;
   localparam logic [7:0] OPC_ERASE_BLOCK = 8'h50;
   localparam logic [7:0] OPC_READ_STATUS = 8'h05;
   localparam int unsigned FRAME_BITS = 32;
   localparam int unsigned ADDR_BITS  = 24;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_PAGE  = 2'd1,
      CMD_BLOCK = 2'd2
   } cmd_kind_e;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int unsigned W = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("sfe_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/sfe_spi_front.sv
module sfe_spi_front
   import sfe_pkg::*;
#(
   parameter int unsigned PAGE_W = 12,
   parameter int unsigned BLK_SHIFT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic              page256,
   input  logic              busy,
   output logic              miso,
   output cmd_kind_e         cmd_kind,
   output logic [PAGE_W-1:0] cmd_page
);
   localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

   logic                  sck_q, cs_q;
   logic                  sck_rise, sck_fall, cs_rise;
   logic [CNT_W-1:0]      bit_cnt;
   logic [FRAME_BITS-1:0] frame;
   logic                  stat_mode;
   logic [7:0]            stat_sh;
   logic [2:0]            stat_idx;
   logic [7:0]            stat_byte;
   logic [7:0]            opcode;
   logic [ADDR_BITS-1:0]  addr;
   logic [PAGE_W-1:0]     page_sel;
   logic [PAGE_W-1:0]     block_base;
   cmd_kind_e             kind_dec;

   assign sck_rise  = sck_s & ~sck_q;
   assign sck_fall  = ~sck_s & sck_q;
   assign cs_rise   = cs_n_s & ~cs_q;
   assign stat_byte = {busy, 6'b000000, page256};
   assign opcode    = frame[FRAME_BITS-1 -: 8];
   assign addr      = frame[ADDR_BITS-1:0];

   always_comb begin
      if (page256) page_sel = addr[PAGE_W+7:8];
      else         page_sel = addr[PAGE_W+8:9];
   end

   assign block_base = {page_sel[PAGE_W-1:BLK_SHIFT], {BLK_SHIFT{1'b0}}};

   always_comb begin
      case (opcode)
         OPC_ERASE_PAGE:  kind_dec = CMD_PAGE;
         OPC_ERASE_BLOCK: kind_dec = CMD_BLOCK;
         default:         kind_dec = CMD_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         cs_q      <= 1'b1;
         bit_cnt   <= '0;
         frame     <= '0;
         stat_mode <= 1'b0;
         stat_sh   <= '0;
         stat_idx  <= '0;
         miso      <= 1'b0;
         cmd_kind  <= CMD_NONE;
         cmd_page  <= '0;
      end else begin
         sck_q    <= sck_s;
         cs_q     <= cs_n_s;
         cmd_kind <= CMD_NONE;
         if (cs_n_s) begin
            bit_cnt   <= '0;
            stat_mode <= 1'b0;
            stat_idx  <= '0;
            miso      <= 1'b0;
         end else begin
            if (sck_rise && bit_cnt != FULL) begin
               frame   <= {frame[FRAME_BITS-2:0], mosi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(7) && {frame[6:0], mosi_s} == OPC_READ_STATUS)
                  stat_mode <= 1'b1;
            end
            if (sck_fall && stat_mode) begin
               stat_idx <= stat_idx + 1'b1;
               if (stat_idx == 3'd0) begin
                  miso    <= stat_byte[7];
                  stat_sh <= {stat_byte[6:0], 1'b0};
               end else begin
                  miso    <= stat_sh[7];
                  stat_sh <= {stat_sh[6:0], 1'b0};
               end
            end
         end
         if (cs_rise && bit_cnt == FULL) begin
            cmd_kind <= kind_dec;
            cmd_page <= (kind_dec == CMD_BLOCK) ? block_base : page_sel;
         end
      end
   end
endmodule

// File: rtl/sfe_erase_seq.sv
module sfe_erase_seq
   import sfe_pkg::*;
#(
   parameter int unsigned PAGE_W = 12,
   parameter int unsigned BLK_SHIFT = 3,
   parameter int unsigned PAGE_CYC = 20000,
   parameter int unsigned BLOCK_CYC = 90000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  cmd_kind_e            cmd_kind,
   input  logic [PAGE_W-1:0]    cmd_page,
   output logic                 busy,
   output logic                 start,
   output logic [PAGE_W-1:0]    first,
   output logic [BLK_SHIFT:0]   count
);
   localparam int unsigned TMR_W = $clog2(BLOCK_CYC + 1);
   localparam logic [TMR_W-1:0] PAGE_LOAD  = TMR_W'(PAGE_CYC - 1);
   localparam logic [TMR_W-1:0] BLOCK_LOAD = TMR_W'(BLOCK_CYC - 1);
   localparam logic [BLK_SHIFT:0] BLK_PAGES = (BLK_SHIFT+1)'(1 << BLK_SHIFT);

   logic [TMR_W-1:0] timer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         start <= 1'b0;
         first <= '0;
         count <= '0;
         timer <= '0;
      end else begin
         start <= 1'b0;
         if (busy) begin
            if (timer == '0) busy  <= 1'b0;
            else             timer <= timer - 1'b1;
         end else if (cmd_kind != CMD_NONE) begin
            start <= 1'b1;
            busy  <= 1'b1;
            first <= cmd_page;
            if (cmd_kind == CMD_BLOCK) begin
               count <= BLK_PAGES;
               timer <= BLOCK_LOAD;
            end else begin
               count <= (BLK_SHIFT+1)'(1);
               timer <= PAGE_LOAD;
            end
         end
      end
   end
endmodule

// File: rtl/sfe_array_model.sv
module sfe_array_model #(
   parameter int unsigned PAGE_W = 12,
   parameter int unsigned BLK_SHIFT = 3,
   parameter int unsigned TRACK_PAGES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PAGE_W-1:0]  first,
   input  logic [BLK_SHIFT:0] count,
   input  logic [PAGE_W-1:0]  probe_page,
   output logic [7:0]         probe_data
);
   localparam int unsigned TRK_W = $clog2(TRACK_PAGES);

   initial begin
      assert (TRACK_PAGES == (1 << TRK_W) && TRK_W <= PAGE_W && TRK_W > 0)
         else $error("sfe_array_model: TRACK_PAGES must be a power of two within the page space");
   end

   logic [TRACK_PAGES-1:0] erased;
   logic [PAGE_W:0]        span_lo, span_hi;

   assign span_lo = {1'b0, first};
   assign span_hi = {1'b0, first} + (PAGE_W+1)'(count);

   for (genvar g = 0; g < TRACK_PAGES; g++) begin : g_page
      localparam logic [PAGE_W:0] IDX = (PAGE_W+1)'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                           erased[g] <= 1'b0;
         else if (start && IDX >= span_lo && IDX < span_hi)     erased[g] <= 1'b1;
      end
   end

   always_comb begin
      if ((probe_page >> TRK_W) == '0 && erased[probe_page[TRK_W-1:0]])
         probe_data = 8'hFF;
      else
         probe_data = 8'h00;
   end
endmodule

// File: rtl/sflash_erase_ctl.sv
module sflash_erase_ctl
   import sfe_pkg::*;
#(
   parameter int unsigned PAGE_W = 12,
   parameter int unsigned BLK_SHIFT = 3,
   parameter int unsigned PAGE_CYC = 20000,
   parameter int unsigned BLOCK_CYC = 90000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TRACK_PAGES = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_sck,
   input  logic               spi_cs_n,
   input  logic               spi_mosi,
   output logic               spi_miso,
   input  logic               page256_mode,
   output logic               erase_busy,
   output logic               arr_erase_start,
   output logic [PAGE_W-1:0]  arr_first_page,
   output logic [BLK_SHIFT:0] arr_page_count,
   input  logic [PAGE_W-1:0]  probe_page,
   output logic [7:0]         probe_data
);
   initial begin
      assert (PAGE_W + 9 <= ADDR_BITS) else $error("sflash_erase_ctl: PAGE_W too wide for address field");
      assert (BLK_SHIFT > 0 && BLK_SHIFT < PAGE_W) else $error("sflash_erase_ctl: bad BLK_SHIFT");
      assert (PAGE_CYC > 0 && BLOCK_CYC > PAGE_CYC) else $error("sflash_erase_ctl: block erase must outlast page erase");
   end

   logic [2:0]        sync_q;
   cmd_kind_e         cmd_kind;
   logic [PAGE_W-1:0] cmd_page;

   sfe_sync #(
      .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_mosi, spi_cs_n, spi_sck}),
      .q(sync_q)
   );

   sfe_spi_front #(
      .PAGE_W(PAGE_W), .BLK_SHIFT(BLK_SHIFT)
   ) u_front (
      .clk(clk), .rst_n(rst_n),
      .sck_s(sync_q[0]), .cs_n_s(sync_q[1]), .mosi_s(sync_q[2]),
      .page256(page256_mode), .busy(erase_busy),
      .miso(spi_miso), .cmd_kind(cmd_kind), .cmd_page(cmd_page)
   );

   sfe_erase_seq #(
      .PAGE_W(PAGE_W), .BLK_SHIFT(BLK_SHIFT),
      .PAGE_CYC(PAGE_CYC), .BLOCK_CYC(BLOCK_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_kind(cmd_kind), .cmd_page(cmd_page),
      .busy(erase_busy), .start(arr_erase_start),
      .first(arr_first_page), .count(arr_page_count)
   );

   sfe_array_model #(
      .PAGE_W(PAGE_W), .BLK_SHIFT(BLK_SHIFT), .TRACK_PAGES(TRACK_PAGES)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .start(arr_erase_start), .first(arr_first_page), .count(arr_page_count),
      .probe_page(probe_page), .probe_data(probe_data)
   );
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk #(
   parameter int unsigned PAGE_W = 12,
   parameter int unsigned BLK_SHIFT = 3,
   parameter int unsigned PAGE_CYC = 20000,
   parameter int unsigned BLOCK_CYC = 90000
) (
   input logic               clk,
   input logic               rst_n,
   input logic               erase_busy,
   input logic               arr_erase_start,
   input logic [PAGE_W-1:0]  arr_first_page,
   input logic [BLK_SHIFT:0] arr_page_count
);
   localparam int unsigned LEN_W = $clog2(BLOCK_CYC + 2);
   localparam logic [BLK_SHIFT:0] BLK_PAGES = (BLK_SHIFT+1)'(1 << BLK_SHIFT);

   logic [LEN_W-1:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy_len <= '0;
      else if (erase_busy) busy_len <= busy_len + 1'b1;
      else                 busy_len <= '0;
   end

   assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      arr_erase_start |=> !arr_erase_start);

   assert_count_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_erase_start |-> (arr_page_count == (BLK_SHIFT+1)'(1) || arr_page_count == BLK_PAGES));

   assert_block_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_erase_start && arr_page_count == BLK_PAGES) |-> (arr_first_page[BLK_SHIFT-1:0] == '0));

   assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_erase_start |-> erase_busy);

   assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_busy) |-> arr_erase_start);

   assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(erase_busy) |-> (busy_len == LEN_W'(PAGE_CYC) || busy_len == LEN_W'(BLOCK_CYC)));

   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(erase_busy) |-> !arr_erase_start);
endmodule

bind sflash_erase_ctl sfe_chk #(
   .PAGE_W(PAGE_W), .BLK_SHIFT(BLK_SHIFT),
   .PAGE_CYC(PAGE_CYC), .BLOCK_CYC(BLOCK_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .erase_busy(erase_busy), .arr_erase_start(arr_erase_start),
   .arr_first_page(arr_first_page), .arr_page_count(arr_page_count)
);

// File: tb/sflash_erase_ctl_tb.sv
module sflash_erase_ctl_tb;
   localparam int PAGE_CYC  = 600;
   localparam int BLOCK_CYC = 1500;
   localparam int HALF      = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic        page256_mode = 1'b0;
   logic        erase_busy;
   logic        arr_erase_start;
   logic [11:0] arr_first_page;
   logic [3:0]  arr_page_count;
   logic [11:0] probe_page = '0;
   logic [7:0]  probe_data;

   int cyc = 0;
   int total = 0;
   int fails = 0;
   bit watching = 0;
   bit done = 0;
   int bs = -1, be = -1;
   int exp_first = 0, exp_cnt = 0;

   always #2 clk = ~clk;

   sflash_erase_ctl #(.PAGE_CYC(PAGE_CYC), .BLOCK_CYC(BLOCK_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .page256_mode(page256_mode), .erase_busy(erase_busy),
      .arr_erase_start(arr_erase_start), .arr_first_page(arr_first_page),
      .arr_page_count(arr_page_count), .probe_page(probe_page), .probe_data(probe_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   always @(posedge clk) cyc++;

   // cycle-by-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (watching) begin
         check(erase_busy == (cyc >= bs && cyc < be), "R7 busy window", int'(erase_busy), int'(cyc >= bs && cyc < be));
         check(arr_erase_start == (cyc == bs), "R5 start timing", int'(arr_erase_start), int'(cyc == bs));
         if (cyc == bs) begin
            check(arr_first_page == 12'(exp_first), "R1 first page", int'(arr_first_page), exp_first);
            check(arr_page_count == 4'(exp_cnt), "R2 page count", int'(arr_page_count), exp_cnt);
         end
      end
   end

   task automatic waitn(input int k);
      repeat (k) @(negedge clk);
   endtask

   // reference decode applied at the chip-select release of cycle n
   task automatic model_release(input logic [31:0] w, input int nbits, input int n);
      int pg;
      if (nbits < 32) return;
      if (w[31:24] != 8'h81 && w[31:24] != 8'h50) return;
      if (n + 4 <= be) return;
      pg = page256_mode ? int'(w[19:8]) : int'(w[20:9]);
      bs = n + 4;
      if (w[31:24] == 8'h50) begin
         exp_first = pg & 12'hFF8; exp_cnt = 8; be = bs + BLOCK_CYC;
      end else begin
         exp_first = pg; exp_cnt = 1; be = bs + PAGE_CYC;
      end
   endtask

   task automatic send_frame(input logic [31:0] w, input int nbits);
      @(negedge clk);
      spi_cs_n = 1'b0;
      waitn(HALF);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = w[31-i];
         waitn(HALF);
         spi_sck = 1'b1;
         waitn(HALF);
         spi_sck = 1'b0;
      end
      waitn(HALF);
      spi_cs_n = 1'b1;
      model_release(w, nbits, cyc);
   endtask

   task automatic read_status(output logic [7:0] val);
      @(negedge clk);
      spi_cs_n = 1'b0;
      waitn(HALF);
      for (int i = 0; i < 8; i++) begin
         spi_mosi = 8'h05 >> (7 - i);
         waitn(HALF);
         spi_sck = 1'b1;
         waitn(HALF);
         spi_sck = 1'b0;
      end
      spi_mosi = 1'b0;
      for (int j = 0; j < 8; j++) begin
         waitn(HALF);
         val[7-j] = spi_miso;
         spi_sck = 1'b1;
         waitn(HALF);
         spi_sck = 1'b0;
      end
      waitn(HALF);
      spi_cs_n = 1'b1;
      waitn(2 * HALF);
   endtask

   task automatic wait_idle();
      while (cyc < be + 2) @(negedge clk);
      waitn(4);
   endtask

   task automatic probe(input int p, input logic [7:0] expv, input string req);
      @(negedge clk);
      probe_page = 12'(p);
      #1;
      check(probe_data == expv, req, int'(probe_data), int'(expv));
   endtask

   task automatic measure_busy(input int expv, input string req);
      int len = 0;
      while (!erase_busy) @(negedge clk);
      while (erase_busy) begin
         len++;
         @(negedge clk);
      end
      check(len == expv, req, len, expv);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual %0d expected finish", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [7:0] st;
      waitn(5);
      rst_n = 1'b1;
      waitn(2);
      // reset state
      check(erase_busy == 1'b0, "R7 reset busy", int'(erase_busy), 0);
      check(arr_erase_start == 1'b0, "R1 reset start", int'(arr_erase_start), 0);
      check(spi_miso == 1'b0, "R9 reset miso", int'(spi_miso), 0);
      probe(5, 8'h00, "R10 reset array");
      watching = 1;

      // R1 / R3: page erase, 264-byte layout, don't-care bits set
      page256_mode = 1'b0;
      send_frame({8'h81, 3'b111, 12'd5, 9'h1FF}, 32);
      measure_busy(PAGE_CYC, "R7 page busy length");
      wait_idle();
      probe(5, 8'hFF, "R10 erased page R3");
      probe(4, 8'h00, "R1 neighbour below");
      probe(6, 8'h00, "R1 neighbour above");

      // R9 idle status, 264 layout
      read_status(st);
      check(st == 8'h00, "R9 idle status", int'(st), 8'h00);

      // R4: page erase, 256-byte layout
      page256_mode = 1'b1;
      send_frame({8'h81, 4'hF, 12'd9, 8'hFF}, 32);
      wait_idle();
      probe(9, 8'hFF, "R4 page erased");
      probe(10, 8'h00, "R4 neighbour");
      read_status(st);
      check(st == 8'h01, "R9 idle status 256 layout", int'(st), 8'h01);

      // R2 / R3: block erase 264 layout, status read during erase
      page256_mode = 1'b0;
      send_frame({8'h50, 3'b111, 9'd3, 12'hFFF}, 32);
      waitn(8);
      read_status(st);
      check(st == 8'h80, "R9 status while busy", int'(st), 8'h80);
      wait_idle();
      probe(24, 8'hFF, "R2 block first page R3");
      probe(31, 8'hFF, "R2 block last page");
      probe(32, 8'h00, "R2 past block");
      probe(23, 8'h00, "R2 before block");

      // R2 / R4: block erase 256 layout, busy length
      page256_mode = 1'b1;
      send_frame({8'h50, 4'hF, 9'd1, 11'h7FF}, 32);
      measure_busy(BLOCK_CYC, "R7 block busy length");
      wait_idle();
      probe(8, 8'hFF, "R4 block first page");
      probe(15, 8'hFF, "R4 block last page");
      probe(16, 8'h00, "R4 past block");

      // highest block, 264 layout (ports checked by the model)
      page256_mode = 1'b0;
      send_frame({8'h50, 3'b000, 9'd511, 12'h000}, 32);
      wait_idle();

      // R5: short frame
      send_frame({8'h81, 3'b000, 12'd20, 9'h000}, 24);
      waitn(PAGE_CYC + 20);
      probe(20, 8'h00, "R5 short frame ignored");

      // R6: unknown opcode
      send_frame({8'h82, 3'b000, 12'd21, 9'h000}, 32);
      waitn(PAGE_CYC + 20);
      probe(21, 8'h00, "R6 unknown opcode ignored");

      // R8: second erase while busy
      send_frame({8'h81, 3'b000, 12'd40, 9'h000}, 32);
      send_frame({8'h81, 3'b000, 12'd41, 9'h000}, 32);
      wait_idle();
      waitn(PAGE_CYC);
      probe(40, 8'hFF, "R8 first erase done");
      probe(41, 8'h00, "R8 busy erase ignored");

      watching = 0;
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule